// File: doc/BRIEF.md
# Jacobian Point Doubling Sequencer

This block doubles a point on a short Weierstrass curve with curve coefficient a = -3 over a small prime field. The input point and the result are both in Jacobian projective coordinates (X, Y, Z). After a one-cycle `start` pulse with the operands on `x_in`, `y_in` and `z_in`, the block runs a fixed program of 22 field operations. These are copies, modular additions, modular subtractions and modular multiplications. They run on a small internal register file that is served by one bit-serial modular multiplier and one single-cycle adder/subtractor.

The hardware has no tripling or halving unit. Three times a value is built from two additions, and halving is a multiplication by a stored constant equal to the inverse of two modulo q. The multiplier always reads two different registers, so every square is formed by first copying the value into a scratch register. The block records whether the input Z is zero before the first step. If it was, the result is replaced by (1, 1, 0), the point at infinity. The program still runs in full for that input, so the latency does not depend on the data.

The field width `W`, the prime `Q` and the constant `INV2` are parameters. Operands are expected to be fully reduced (below `Q`).

Top module: `jacobian_double_seq`

## Requirements
- R1: Out of reset, `busy` and `done` are 0 and `x_out`, `y_out`, `z_out` are all 0.
- R2: For an input with Z ≠ 0, with M = 3(X − Z²)(X + Z²) and S = 4XY² (all mod q), the result is x_out = M² − 2S, y_out = M(S − x_out) − 8Y⁴ and z_out = 2YZ, each reduced into [0, q).
- R3: When the sampled input Z is 0, the result is x_out = 1, y_out = 1, z_out = 0, whatever X and Y were.
- R4: `busy` is 1 from the cycle after an accepted `start` until `done` rises. `done` is a one-cycle pulse, and `busy` is 0 while `done` is 1.
- R5: `x_out`, `y_out` and `z_out` change only on the edge that raises `done`, and they hold their value until the next result.
- R6: A `start` pulse that arrives while `busy` is 1 is ignored. The running computation finishes with the operands of the accepted start.
- R7: The number of cycles from `start` to `done` is the same for every input, including Z = 0.
- R8: The multiplier is started only when it is idle, and the two registers it reads in that step are different registers.
- R9: Every value written into the working registers, and every partial product inside the multiplier, is below q.
- R10: An input with Y = 0 and Z ≠ 0 is not treated as infinity. It yields the arithmetic result of R2, where z_out is 0 and x_out, y_out come from the formulas.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to double the point on the operand inputs |
| x_in | input | W | Jacobian X of the input point |
| y_in | input | W | Jacobian Y of the input point |
| z_in | input | W | Jacobian Z of the input point |
| busy | output | 1 | A doubling is in progress |
| done | output | 1 | One-cycle pulse: result outputs just updated |
| x_out | output | W | Jacobian X of the doubled point |
| y_out | output | W | Jacobian Y of the doubled point |
| z_out | output | W | Jacobian Z of the doubled point |

## Verification
On every cycle the assertions check the microprogram's structural rules: the multiplier never reads the same register twice and is never restarted while it runs, every written register value and every multiplier partial result stays reduced, `done` is a single-cycle pulse with `busy` low, and the outputs move only on a `done` edge. The bench's scenarios cover what only end-to-end results show. These are the correctness of the arithmetic, which is compared against the textbook doubling formulas over a near-exhaustive sweep of a 5-bit field, the forced infinity result, the Y = 0 case, the equal latency across all inputs, and a start pulse ignored in mid-run.

// File: rtl/jd_pkg.sv
// Shared types for the Jacobian doubling sequencer: opcodes, register
// names, the step record and the fixed microprogram.
// Assumes: the program ends with a non-multiply step (any op works, though).
package jd_pkg;

    typedef enum logic [1:0] {OP_COPY, OP_ADD, OP_SUB, OP_MUL} op_e;

    typedef enum logic [3:0] {
        RG_X, RG_Y, RG_Z, RG_T1, RG_T2, RG_T3, RG_RX, RG_RY, RG_RZ, RG_DL
    } reg_e;

    localparam int NREG   = 10;
    localparam int NSTEPS = 22;
    localparam int PCW    = $clog2(NSTEPS);

    typedef struct packed {
        op_e  op;
        reg_e dst;
        reg_e a;
        reg_e b;
    } step_t;

    // Microprogram: dst = a op b (COPY uses a only). Squares copy first.
    function automatic step_t step_at(input logic [PCW-1:0] pc);
        case (pc)
            5'd0:  return '{OP_COPY, RG_T1, RG_Z,  RG_Z };
            5'd1:  return '{OP_MUL,  RG_T1, RG_Z,  RG_T1};
            5'd2:  return '{OP_SUB,  RG_T2, RG_X,  RG_T1};
            5'd3:  return '{OP_ADD,  RG_T1, RG_X,  RG_T1};
            5'd4:  return '{OP_MUL,  RG_T2, RG_T1, RG_T2};
            5'd5:  return '{OP_ADD,  RG_T1, RG_T2, RG_T2};
            5'd6:  return '{OP_ADD,  RG_T2, RG_T1, RG_T2};
            5'd7:  return '{OP_ADD,  RG_RY, RG_Y,  RG_Y };
            5'd8:  return '{OP_MUL,  RG_RZ, RG_Z,  RG_RY};
            5'd9:  return '{OP_COPY, RG_T1, RG_RY, RG_RY};
            5'd10: return '{OP_MUL,  RG_RY, RG_RY, RG_T1};
            5'd11: return '{OP_MUL,  RG_T3, RG_X,  RG_RY};
            5'd12: return '{OP_COPY, RG_T1, RG_RY, RG_RY};
            5'd13: return '{OP_MUL,  RG_T1, RG_RY, RG_T1};
            5'd14: return '{OP_MUL,  RG_RY, RG_T1, RG_DL};
            5'd15: return '{OP_COPY, RG_T1, RG_T2, RG_T2};
            5'd16: return '{OP_MUL,  RG_RX, RG_T1, RG_T2};
            5'd17: return '{OP_ADD,  RG_T1, RG_T3, RG_T3};
            5'd18: return '{OP_SUB,  RG_RX, RG_RX, RG_T1};
            5'd19: return '{OP_SUB,  RG_T1, RG_T3, RG_RX};
            5'd20: return '{OP_MUL,  RG_T1, RG_T1, RG_T2};
            5'd21: return '{OP_SUB,  RG_RY, RG_T1, RG_RY};
            default: return '{OP_COPY, RG_T1, RG_T1, RG_T1};
        endcase
    endfunction

endpackage

// File: rtl/jd_modaddsub.sv
// Single-cycle modular adder/subtractor.
// Computes a+b or a-b modulo Q with one conditional correction.
// Assumes: a < Q and b < Q.
module jd_modaddsub #(
    parameter int W = 8,
    parameter int Q = 251
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] r
);
    localparam logic [W:0] QW = (W+1)'(Q);

    logic [W:0] sum;
    logic [W:0] dif;

    // Add or subtract, then fold the result back into [0, Q).
    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        dif = {1'b0, a} - {1'b0, b};
        if (sub) begin
            r = (a < b) ? W'(dif + QW) : W'(dif);
        end else begin
            r = (sum >= QW) ? W'(sum - QW) : W'(sum);
        end
    end
endmodule

// File: rtl/jd_modmul.sv
// Bit-serial modular multiplier, MSB first: acc = 2*acc (+a) mod Q per cycle.
// A go pulse latches both operands; fin pulses one cycle after the last bit,
// with the product on p. Assumes a, b < Q and go only while idle.
module jd_modmul #(
    parameter int W = 8,
    parameter int Q = 251
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         running,
    output logic         fin,
    output logic [W-1:0] p
);
    localparam int         CW = $clog2(W + 1);
    localparam logic [W:0] QW = (W+1)'(Q);

    logic [W-1:0] a_q, b_q, acc, nxt;
    logic [CW-1:0] cnt;
    logic [W:0] two, two_r, sum;

    // One shift-and-add step with reduction after each half.
    always_comb begin
        two   = {acc, 1'b0};
        two_r = (two >= QW) ? (two - QW) : two;
        sum   = two_r + {1'b0, a_q};
        if (b_q[W-1]) nxt = (sum >= QW) ? W'(sum - QW) : W'(sum);
        else          nxt = W'(two_r);
    end

    // Operand capture, bit iteration and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0; b_q <= '0; acc <= '0; cnt <= '0;
            running <= 1'b0; fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                a_q <= a; b_q <= b; acc <= '0;
                cnt <= CW'(W); running <= 1'b1;
            end else if (running) begin
                acc <= nxt;
                b_q <= b_q << 1;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
        end
    end

    assign p = acc;

    assert_mul_acc_reduced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc < W'(Q));
    assert_mul_go_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !running);
endmodule

// File: rtl/jd_regfile.sv
// Working register file: X, Y, Z operands, three scratch registers, the
// three result coordinates and a read-only inverse-of-two constant.
// One write port, two combinational read ports; load captures operands.
module jd_regfile
    import jd_pkg::*;
#(
    parameter int W    = 8,
    parameter int INV2 = 126
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_x,
    input  logic [W-1:0] ld_y,
    input  logic [W-1:0] ld_z,
    input  logic         we,
    input  reg_e         wsel,
    input  logic [W-1:0] wdata,
    input  reg_e         sel_a,
    input  reg_e         sel_b,
    output logic [W-1:0] rd_a,
    output logic [W-1:0] rd_b,
    output logic [W-1:0] res_x,
    output logic [W-1:0] res_y,
    output logic [W-1:0] res_z
);
    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == int'(RG_DL)) begin : g_const
            assign regs[g] = W'(INV2);
        end else begin : g_flop
            logic [W-1:0] q;
            // Register g: operand load on start, else program write.
            always_ff @(posedge clk) begin
                if (!rst_n)                                q <= '0;
                else if (load && g == int'(RG_X))          q <= ld_x;
                else if (load && g == int'(RG_Y))          q <= ld_y;
                else if (load && g == int'(RG_Z))          q <= ld_z;
                else if (we && int'(wsel) == g)            q <= wdata;
            end
            assign regs[g] = q;
        end
    end

    assign rd_a  = regs[sel_a];
    assign rd_b  = regs[sel_b];
    assign res_x = regs[RG_RX];
    assign res_y = regs[RG_RY];
    assign res_z = regs[RG_RZ];
endmodule

// File: rtl/jacobian_double_seq.sv
// Jacobian point doubling sequencer for a = -3 curves over GF(Q).
// Steps the fixed microprogram in jd_pkg over the register file, one
// add/sub/copy per cycle, multiplies through jd_modmul. Z == 0 at start
// forces the result to (1, 1, 0). Assumes operands below Q, INV2*2 = 1 mod Q.
module jacobian_double_seq
    import jd_pkg::*;
#(
    parameter int W    = 8,
    parameter int Q    = 251,
    parameter int INV2 = 126
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] z_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] x_out,
    output logic [W-1:0] y_out,
    output logic [W-1:0] z_out
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_MWAIT, S_FIN} st_e;

    st_e            state;
    logic [PCW-1:0] pc;
    logic           inf_q;
    step_t          cur;
    logic           we, mul_go, mul_run, mul_fin, last, load;
    logic [W-1:0]   wdata, rd_a, rd_b, as_r, mul_p, res_x, res_y, res_z;

    assign cur  = step_at(pc);
    assign last = (pc == PCW'(NSTEPS - 1));
    assign load = (state == S_IDLE) && start;

    jd_regfile #(.W(W), .INV2(INV2)) u_rf (
        .clk(clk), .rst_n(rst_n), .load(load),
        .ld_x(x_in), .ld_y(y_in), .ld_z(z_in),
        .we(we), .wsel(cur.dst), .wdata(wdata),
        .sel_a(cur.a), .sel_b(cur.b), .rd_a(rd_a), .rd_b(rd_b),
        .res_x(res_x), .res_y(res_y), .res_z(res_z)
    );

    jd_modaddsub #(.W(W), .Q(Q)) u_as (
        .a(rd_a), .b(rd_b), .sub(cur.op == OP_SUB), .r(as_r)
    );

    jd_modmul #(.W(W), .Q(Q)) u_mul (
        .clk(clk), .rst_n(rst_n), .go(mul_go), .a(rd_a), .b(rd_b),
        .running(mul_run), .fin(mul_fin), .p(mul_p)
    );

    // Decode the current step into a register write or a multiplier launch.
    always_comb begin
        we     = 1'b0;
        mul_go = 1'b0;
        wdata  = as_r;
        if (state == S_RUN) begin
            case (cur.op)
                OP_COPY: begin we = 1'b1; wdata = rd_a; end
                OP_ADD,
                OP_SUB:  we = 1'b1;
                OP_MUL:  mul_go = 1'b1;
                default: we = 1'b0;
            endcase
        end else if (state == S_MWAIT && mul_fin) begin
            we    = 1'b1;
            wdata = mul_p;
        end
    end

    // Program counter, state and result publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; pc <= '0; inf_q <= 1'b0;
            busy <= 1'b0; done <= 1'b0;
            x_out <= '0; y_out <= '0; z_out <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    state <= S_RUN; pc <= '0; busy <= 1'b1;
                    inf_q <= (z_in == '0);
                end
                S_RUN: begin
                    if (cur.op == OP_MUL) state <= S_MWAIT;
                    else if (last)        state <= S_FIN;
                    else                  pc <= pc + 1'b1;
                end
                S_MWAIT: if (mul_fin) begin
                    if (last) state <= S_FIN;
                    else begin state <= S_RUN; pc <= pc + 1'b1; end
                end
                S_FIN: begin
                    state <= S_IDLE; busy <= 1'b0; done <= 1'b1;
                    x_out <= inf_q ? W'(1) : res_x;
                    y_out <= inf_q ? W'(1) : res_y;
                    z_out <= inf_q ? '0    : res_z;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_mul_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |-> (cur.a != cur.b));
    assert_write_reduced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wdata < W'(Q)));
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(x_out) && $stable(y_out) && $stable(z_out)));
endmodule

// File: tb/tb_jacobian_double_seq.sv
`timescale 1ns/1ps
module tb_jacobian_double_seq;
    localparam int W = 5;
    localparam int Q = 31;
    localparam int INV2 = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] x_in = '0, y_in = '0, z_in = '0;
    logic busy, done;
    logic [W-1:0] x_out, y_out, z_out;

    int checks = 0;
    int errors = 0;
    int ref_lat = -1;

    always #4 clk = ~clk;

    jacobian_double_seq #(.W(W), .Q(Q), .INV2(INV2)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .busy(busy), .done(done),
        .x_out(x_out), .y_out(y_out), .z_out(z_out)
    );

    function automatic int md(int v);
        return ((v % Q) + Q) % Q;
    endfunction

    // Textbook doubling for a = -3, independent of the microprogram order.
    task automatic expect_dbl(input int x, y, z, output int ex, ey, ez);
        int z2, m, y2, s;
        if (z == 0) begin ex = 1; ey = 1; ez = 0; return; end
        z2 = md(z * z);
        m  = md(3 * md(x - z2) * md(x + z2));
        y2 = md(y * y);
        s  = md(4 * x * y2);
        ex = md(m * m - 2 * s);
        ey = md(m * md(s - ex) - 8 * md(y2 * y2));
        ez = md(2 * y * z);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_pt(input string req, input int x, y, z);
        int ex, ey, ez;
        expect_dbl(x, y, z, ex, ey, ez);
        checks++;
        if (int'(x_out) != ex || int'(y_out) != ey || int'(z_out) != ez) begin
            errors++;
            $display("FAIL %s in=(%0d,%0d,%0d): actual=(%0d,%0d,%0d) expected=(%0d,%0d,%0d)",
                     req, x, y, z, x_out, y_out, z_out, ex, ey, ez);
        end
    endtask

    // Start one doubling, optionally poke start mid-run, wait for done.
    task automatic run(input int x, y, z, input bit poke, output int lat);
        @(negedge clk);
        start = 1'b1; x_in = W'(x); y_in = W'(y); z_in = W'(z);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk(busy == 1'b1, "R4", "busy after start", int'(busy), 1);
        while (!done) begin
            if (poke && lat == 10) begin
                start = 1'b1; x_in = W'(x + 3); y_in = W'(y + 1); z_in = '0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        int ys[5] = '{0, 1, 2, 15, 30};
        int zs[5] = '{0, 1, 3, 16, 30};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0, "R1", "busy/done in reset", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(x_out == 0 && y_out == 0 && z_out == 0, "R1", "outputs after reset",
            int'({x_out, y_out, z_out}), 0);

        // R2/R3/R7: near-exhaustive sweep
        for (int x = 0; x < Q; x++) begin
            for (int yi = 0; yi < 5; yi++) begin
                for (int zi = 0; zi < 5; zi++) begin
                    run(x, ys[yi], zs[zi], 1'b0, lat);
                    chk_pt(zs[zi] == 0 ? "R3" : (ys[yi] == 0 ? "R10" : "R2"),
                           x, ys[yi], zs[zi]);
                    if (ref_lat < 0) ref_lat = lat;
                    chk(lat == ref_lat, "R7", "latency", lat, ref_lat);
                    @(negedge clk);
                    chk(done == 0, "R4", "done single cycle", int'(done), 0);
                end
            end
        end

        // R2: full Z sweep with fixed X, Y
        for (int z = 0; z < Q; z++) begin
            run(5, 7, z, 1'b0, lat);
            chk_pt(z == 0 ? "R3" : "R2", 5, 7, z);
        end

        // R10: Y = 0, Z nonzero must follow the arithmetic
        run(9, 0, 4, 1'b0, lat);
        chk_pt("R10", 9, 0, 4);

        // R6: mid-run start ignored
        run(11, 13, 6, 1'b1, lat);
        chk_pt("R6", 11, 13, 6);
        chk(lat == ref_lat, "R6", "latency with ignored start", lat, ref_lat);

        // R5: hold outputs while idle
        repeat (25) @(negedge clk);
        chk_pt("R5", 11, 13, 6);
        chk(busy == 0 && done == 0, "R5", "idle after ignored start",
            int'({busy, done}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule